// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides which value a fused `(a*b)+c` unit returns when NaNs are involved. For each of the three operands it takes a class code: an ordinary number, a quiet NaN or a signaling NaN. It also takes a flag, computed outside the block, that says the product is infinity times zero, and a policy select. From these it produces a 2-bit choice code and two exception bits: the invalid-operation flag and a sub-flag that marks an invalid caused by infinity times zero.

A surrounding wrapper uses the choice code. It either forwards the selected operand, quieted if needed, or substitutes the default NaN. The policies differ in two ways: the order in which the three operands win, and how the infinity-times-zero product is handled. One policy also has a run-time switch that reverses its order.

All three outputs are registered together, one cycle after the inputs are presented.

Top module: `fmanan_sel`

## Requirements
- R1: The choice code and both flags are registered. They reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they are all zero.
- R2: Class codes: 0 is an ordinary number, 1 is a quiet NaN, 2 is a signaling NaN, and 3 is treated as an ordinary number. Choice codes: 0 selects a, 1 selects b, 2 selects c, 3 selects the default NaN.
- R3: Policy 0. If infinity-times-zero is set and c is a quiet NaN, the choice is 3. Otherwise the first match wins in this order: signaling c, signaling a, signaling b, quiet c, quiet a. If none match, the choice is b.
- R4: Policy 1. Infinity-times-zero gives choice 3. Otherwise the first match wins in this order: signaling a, signaling b, signaling c, quiet a, quiet b. If none match, the choice is c.
- R5: Policy 2. Infinity-times-zero gives choice 2. Otherwise it uses the same order as policy 0.
- R6: Policy 3. Infinity-times-zero gives choice 2. Otherwise the choice is a if a is any NaN, else c if c is any NaN, else b.
- R7: Policy 4. The choice is always 3, whatever the inputs.
- R8: Policy 5. Infinity-times-zero gives choice 2. Otherwise, with `use_first_i` set, the first NaN in the order a, b, c wins. With it clear, the first NaN in the order c, b, a wins. `use_first_i` has no effect under any other policy.
- R9: Policies 6 and 7. The choice is the first NaN in the order a, b, c, else c. Infinity-times-zero does not alter the choice.
- R10: The sub-flag `invalid_imz_o` is raised when infinity-times-zero is set. Under policy 0 it is raised only when c is also a quiet NaN. `invalid_o` is raised whenever the sub-flag is raised or any operand is a signaling NaN.
- R11: Both flags are zero when no operand is a NaN and infinity-times-zero is clear.
- R12: When infinity-times-zero is clear, at least one operand is a NaN, and the policy is not 4, the selected operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_a_i | input | 2 | Class code of operand a (multiplicand) |
| cls_b_i | input | 2 | Class code of operand b (multiplier) |
| cls_c_i | input | 2 | Class code of operand c (addend) |
| imz_i | input | 1 | Product is infinity times zero |
| use_first_i | input | 1 | Order switch for policy 5 |
| policy_i | input | 3 | Policy select |
| choice_o | output | 2 | Selected result source |
| invalid_o | output | 1 | Invalid-operation flag |
| invalid_imz_o | output | 1 | Invalid caused by infinity times zero |

## Verification
The hardest cases to reach are those where infinity-times-zero meets NaN operands. One example is policy 0 with c signaling rather than quiet, where the sub-flag must stay low but invalid must still rise. Another is a reserved class code standing beside a real NaN. These only show up under particular policy, class and switch combinations. The stimulus therefore sweeps all 64 class triples, both infinity-times-zero values and both switch values for every policy code. Each result is compared against a model written from the priority lists, and directed reset and reserved-code tasks are added on top.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;

  localparam int CLS_W    = 2;
  localparam int CHOICE_W = 2;
  localparam int POL_W    = 3;
  localparam int NUM_POL  = 1 << POL_W;
  localparam int NUM_OPS  = 3;
  localparam int PACK_W   = NUM_OPS * CLS_W;

  // class codes
  localparam logic [CLS_W-1:0] CLS_NUM    = 2'd0;
  localparam logic [CLS_W-1:0] CLS_QUIET  = 2'd1;
  localparam logic [CLS_W-1:0] CLS_SIGNAL = 2'd2;

  // choice codes
  localparam logic [CHOICE_W-1:0] PICK_A    = 2'd0;
  localparam logic [CHOICE_W-1:0] PICK_B    = 2'd1;
  localparam logic [CHOICE_W-1:0] PICK_C    = 2'd2;
  localparam logic [CHOICE_W-1:0] PICK_DFLT = 2'd3;

  // policy codes
  localparam logic [POL_W-1:0] POL_CAB_QIMZ  = 3'd0;
  localparam logic [POL_W-1:0] POL_ABC_DFLT  = 3'd1;
  localparam logic [POL_W-1:0] POL_CAB_RETC  = 3'd2;
  localparam logic [POL_W-1:0] POL_ACB_ANY   = 3'd3;
  localparam logic [POL_W-1:0] POL_ALL_DFLT  = 3'd4;
  localparam logic [POL_W-1:0] POL_SWITCHED  = 3'd5;

  // operand orders, first winner in the low field
  localparam logic [PACK_W-1:0] ORD_ABC = {PICK_C, PICK_B, PICK_A};
  localparam logic [PACK_W-1:0] ORD_CAB = {PICK_B, PICK_A, PICK_C};
  localparam logic [PACK_W-1:0] ORD_CBA = {PICK_A, PICK_B, PICK_C};
  localparam logic [PACK_W-1:0] ORD_ACB = {PICK_B, PICK_C, PICK_A};

  function automatic logic is_quiet(input logic [CLS_W-1:0] c);
    return c == CLS_QUIET;
  endfunction

  function automatic logic is_signal(input logic [CLS_W-1:0] c);
    return c == CLS_SIGNAL;
  endfunction

  function automatic logic is_nan(input logic [CLS_W-1:0] c);
    return is_quiet(c) || is_signal(c);
  endfunction

  // signaling operands first in the given order, then quiet ones, else last
  function automatic logic [CHOICE_W-1:0] pick_tiered(input logic [PACK_W-1:0] cls3,
                                                      input logic [PACK_W-1:0] order);
    logic [CHOICE_W-1:0] res;
    logic [CHOICE_W-1:0] idx;
    logic                hit;
    res = order[PACK_W-1 -: CHOICE_W];
    hit = 1'b0;
    for (int k = 0; k < NUM_OPS; k++) begin
      idx = order[CHOICE_W*k +: CHOICE_W];
      if (!hit && is_signal(cls3[{idx, 1'b0} +: CLS_W])) begin
        res = idx;
        hit = 1'b1;
      end
    end
    for (int k = 0; k < NUM_OPS; k++) begin
      idx = order[CHOICE_W*k +: CHOICE_W];
      if (!hit && is_quiet(cls3[{idx, 1'b0} +: CLS_W])) begin
        res = idx;
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  // first NaN of either kind in the given order, else last
  function automatic logic [CHOICE_W-1:0] pick_any(input logic [PACK_W-1:0] cls3,
                                                   input logic [PACK_W-1:0] order);
    logic [CHOICE_W-1:0] res;
    logic [CHOICE_W-1:0] idx;
    logic                hit;
    res = order[PACK_W-1 -: CHOICE_W];
    hit = 1'b0;
    for (int k = 0; k < NUM_OPS; k++) begin
      idx = order[CHOICE_W*k +: CHOICE_W];
      if (!hit && is_nan(cls3[{idx, 1'b0} +: CLS_W])) begin
        res = idx;
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  // full per-policy decision
  function automatic logic [CHOICE_W-1:0] policy_pick(input logic [POL_W-1:0]  pol,
                                                      input logic [PACK_W-1:0] cls3,
                                                      input logic              imz,
                                                      input logic              use_first);
    logic [CHOICE_W-1:0] r;
    case (pol)
      POL_CAB_QIMZ:
        r = (imz && is_quiet(cls3[2*CLS_W +: CLS_W])) ? PICK_DFLT : pick_tiered(cls3, ORD_CAB);
      POL_ABC_DFLT:
        r = imz ? PICK_DFLT : pick_tiered(cls3, ORD_ABC);
      POL_CAB_RETC:
        r = imz ? PICK_C : pick_tiered(cls3, ORD_CAB);
      POL_ACB_ANY:
        r = imz ? PICK_C : pick_any(cls3, ORD_ACB);
      POL_ALL_DFLT:
        r = PICK_DFLT;
      POL_SWITCHED:
        r = imz ? PICK_C : pick_any(cls3, use_first ? ORD_ABC : ORD_CBA);
      default:
        r = pick_any(cls3, ORD_ABC);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fmanan_order.sv
module fmanan_order
  import fmanan_pkg::*;
(
  input  logic [PACK_W-1:0]   cls3_i,
  input  logic                imz_i,
  input  logic                use_first_i,
  input  logic [POL_W-1:0]    policy_i,
  output logic [CHOICE_W-1:0] choice_o
);

  logic [CHOICE_W-1:0] cand [NUM_POL];

  // one candidate per policy code, evaluated in parallel
  for (genvar gp = 0; gp < NUM_POL; gp++) begin : g_pol
    assign cand[gp] = policy_pick(POL_W'(gp), cls3_i, imz_i, use_first_i);
  end

  assign choice_o = cand[policy_i];

endmodule

// File: rtl/fmanan_flags.sv
module fmanan_flags
  import fmanan_pkg::*;
(
  input  logic [PACK_W-1:0] cls3_i,
  input  logic              imz_i,
  input  logic [POL_W-1:0]  policy_i,
  output logic              snan_seen_o,
  output logic              imz_raise_o,
  output logic              invalid_o
);

  logic [NUM_OPS-1:0] sig_vec;

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
    assign sig_vec[gi] = is_signal(cls3_i[gi*CLS_W +: CLS_W]);
  end

  assign snan_seen_o = |sig_vec;
  assign imz_raise_o = imz_i &&
                       ((policy_i != POL_CAB_QIMZ) || is_quiet(cls3_i[2*CLS_W +: CLS_W]));
  assign invalid_o   = snan_seen_o || imz_raise_o;

endmodule

// File: rtl/fmanan_sel.sv
module fmanan_sel
  import fmanan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CLS_W-1:0]    cls_a_i,
  input  logic [CLS_W-1:0]    cls_b_i,
  input  logic [CLS_W-1:0]    cls_c_i,
  input  logic                imz_i,
  input  logic                use_first_i,
  input  logic [POL_W-1:0]    policy_i,
  output logic [CHOICE_W-1:0] choice_o,
  output logic                invalid_o,
  output logic                invalid_imz_o
);

  logic [PACK_W-1:0]   cls3_w;
  logic [CHOICE_W-1:0] choice_w;
  logic                snan_seen_w;
  logic                imz_raise_w;
  logic                invalid_w;

  assign cls3_w = {cls_c_i, cls_b_i, cls_a_i};

  fmanan_order u_order (
    .cls3_i      (cls3_w),
    .imz_i       (imz_i),
    .use_first_i (use_first_i),
    .policy_i    (policy_i),
    .choice_o    (choice_w)
  );

  fmanan_flags u_flags (
    .cls3_i      (cls3_w),
    .imz_i       (imz_i),
    .policy_i    (policy_i),
    .snan_seen_o (snan_seen_w),
    .imz_raise_o (imz_raise_w),
    .invalid_o   (invalid_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      choice_o      <= PICK_A;
      invalid_o     <= 1'b0;
      invalid_imz_o <= 1'b0;
    end else begin
      choice_o      <= choice_w;
      invalid_o     <= invalid_w;
      invalid_imz_o <= imz_raise_w;
    end
  end

endmodule

// File: rtl/fmanan_sel_chk.sv
module fmanan_sel_chk
  import fmanan_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [CLS_W-1:0]    cls_a_i,
  input logic [CLS_W-1:0]    cls_b_i,
  input logic [CLS_W-1:0]    cls_c_i,
  input logic                imz_i,
  input logic [POL_W-1:0]    policy_i,
  input logic [CHOICE_W-1:0] choice_o,
  input logic                invalid_o,
  input logic                invalid_imz_o,
  input logic                snan_seen_w
);

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  logic any_nan;
  assign any_nan = is_nan(cls_a_i) || is_nan(cls_b_i) || is_nan(cls_c_i);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (choice_o == PICK_A && !invalid_o && !invalid_imz_o));

  a_r10_imz_implies_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_imz_o |-> invalid_o);

  a_r10_snan_raises_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(snan_seen_w)) |-> invalid_o);

  a_r11_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!any_nan && !imz_i)) |-> (!invalid_o && !invalid_imz_o));

  a_r7_always_default: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(policy_i == POL_ALL_DFLT)) |-> (choice_o == PICK_DFLT));

  a_r12_nan_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!imz_i && any_nan && policy_i != POL_ALL_DFLT)) |->
      ((choice_o == PICK_A && is_nan($past(cls_a_i))) ||
       (choice_o == PICK_B && is_nan($past(cls_b_i))) ||
       (choice_o == PICK_C && is_nan($past(cls_c_i)))));

endmodule

bind fmanan_sel fmanan_sel_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cls_a_i       (cls_a_i),
  .cls_b_i       (cls_b_i),
  .cls_c_i       (cls_c_i),
  .imz_i         (imz_i),
  .policy_i      (policy_i),
  .choice_o      (choice_o),
  .invalid_o     (invalid_o),
  .invalid_imz_o (invalid_imz_o),
  .snan_seen_w   (snan_seen_w)
);

// File: tb/fmanan_sel_bench.sv
module fmanan_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cls_a = 2'd0, cls_b = 2'd0, cls_c = 2'd0;
  logic       imz = 1'b0, use_first = 1'b0;
  logic [2:0] policy = 3'd0;
  logic [1:0] choice;
  logic       inv, inv_imz;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmanan_sel u_fmanan_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .cls_a_i       (cls_a),
    .cls_b_i       (cls_b),
    .cls_c_i       (cls_c),
    .imz_i         (imz),
    .use_first_i   (use_first),
    .policy_i      (policy),
    .choice_o      (choice),
    .invalid_o     (inv),
    .invalid_imz_o (inv_imz)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic bit q_of(input logic [1:0] c); return c == 2'd1; endfunction
  function automatic bit s_of(input logic [1:0] c); return c == 2'd2; endfunction

  function automatic logic [1:0] ref_choice(input int pol, input logic [1:0] ca, cb, cc,
                                            input bit iz, input bit uf);
    bit sa = s_of(ca), sb = s_of(cb), sc = s_of(cc);
    bit qa = q_of(ca), qb = q_of(cb), qc = q_of(cc);
    bit na = sa | qa, nb = sb | qb, nc = sc | qc;
    if (pol == 0) begin            // R3
      if (iz && qc) return 2'd3;
      if (sc) return 2'd2; if (sa) return 2'd0; if (sb) return 2'd1;
      if (qc) return 2'd2; if (qa) return 2'd0; return 2'd1;
    end else if (pol == 1) begin   // R4
      if (iz) return 2'd3;
      if (sa) return 2'd0; if (sb) return 2'd1; if (sc) return 2'd2;
      if (qa) return 2'd0; if (qb) return 2'd1; return 2'd2;
    end else if (pol == 2) begin   // R5
      if (iz) return 2'd2;
      if (sc) return 2'd2; if (sa) return 2'd0; if (sb) return 2'd1;
      if (qc) return 2'd2; if (qa) return 2'd0; return 2'd1;
    end else if (pol == 3) begin   // R6
      if (iz) return 2'd2;
      if (na) return 2'd0; if (nc) return 2'd2; return 2'd1;
    end else if (pol == 4) begin   // R7
      return 2'd3;
    end else if (pol == 5) begin   // R8
      if (iz) return 2'd2;
      if (uf) begin
        if (na) return 2'd0; if (nb) return 2'd1; return 2'd2;
      end
      if (nc) return 2'd2; if (nb) return 2'd1; return 2'd0;
    end
    if (na) return 2'd0;           // R9
    if (nb) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d (pol=%0d a=%0d b=%0d c=%0d iz=%0d uf=%0d)",
               tag, what, got, exp, policy, cls_a, cls_b, cls_c, imz, use_first);
    end
  endtask

  // drive on the falling edge, result visible after the next rising edge
  task automatic apply(input int pol, input logic [1:0] ca, cb, cc, input bit iz, input bit uf);
    @(negedge clk);
    policy = pol[2:0]; cls_a = ca; cls_b = cb; cls_c = cc; imz = iz; use_first = uf;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    policy = 3'd4; cls_a = 2'd2; imz = 1'b1;
    @(posedge clk); #1;
    check("R1", "choice in reset", choice, 0);
    check("R1", "invalid in reset", inv, 0);
    check("R1", "imz flag in reset", inv_imz, 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(4, 2'd2, 2'd0, 2'd0, 1'b1, 1'b0);
    check("R1", "choice one cycle after release", choice, 3);
    check("R1", "invalid one cycle after release", inv, 1);
  endtask

  task automatic t_sweep(input int pol, input string tag);
    for (int uf = 0; uf < 2; uf++)
      for (int iz = 0; iz < 2; iz++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
              bit exp_imz, exp_inv, anynan, anysig;
              logic [1:0] ec;
              logic [1:0] chosen_cls;
              apply(pol, a[1:0], b[1:0], c[1:0], iz[0], uf[0]);
              ec = ref_choice(pol, a[1:0], b[1:0], c[1:0], iz[0], uf[0]);
              check(tag, "choice", choice, ec);
              anysig = s_of(a[1:0]) | s_of(b[1:0]) | s_of(c[1:0]);
              anynan = anysig | q_of(a[1:0]) | q_of(b[1:0]) | q_of(c[1:0]);
              exp_imz = (pol == 0) ? (iz[0] && q_of(c[1:0])) : iz[0];
              exp_inv = exp_imz | anysig;
              if (!anynan && iz == 0) begin
                check("R11", "invalid", inv, 0);
                check("R11", "imz flag", inv_imz, 0);
              end else begin
                check("R10", "invalid", inv, exp_inv);
                check("R10", "imz flag", inv_imz, exp_imz);
              end
              if (iz == 0 && anynan && pol != 4) begin
                chosen_cls = (choice == 2'd0) ? a[1:0] : (choice == 2'd1) ? b[1:0] :
                             (choice == 2'd2) ? c[1:0] : 2'd0;
                check("R12", "selected operand is NaN",
                      int'(q_of(chosen_cls) | s_of(chosen_cls)), 1);
              end
            end
  endtask

  // R2: reserved class code 3 behaves as an ordinary number
  task automatic t_reserved_class;
    apply(6, 2'd3, 2'd1, 2'd3, 1'b0, 1'b0);
    check("R2", "reserved a skipped", choice, 1);
    check("R2", "reserved gives no invalid", inv, 0);
    apply(1, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0);
    check("R2", "all reserved, quiet flags", inv, 0);
  endtask

  // R8: the order switch changes nothing outside policy 5
  task automatic t_switch_scope;
    apply(3, 2'd0, 2'd1, 2'd1, 1'b0, 1'b1);
    check("R8", "switch ignored under policy 3", choice, 2);
    apply(5, 2'd0, 2'd1, 2'd1, 1'b0, 1'b1);
    check("R8", "switch set picks b", choice, 1);
    apply(5, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0);
    check("R8", "switch clear picks c", choice, 2);
  endtask

  initial begin
    t_reset();
    t_sweep(0, "R3");
    t_sweep(1, "R4");
    t_sweep(2, "R5");
    t_sweep(3, "R6");
    t_sweep(4, "R7");
    t_sweep(5, "R8");
    t_sweep(6, "R9");
    t_sweep(7, "R9");
    t_reserved_class();
    t_switch_scope();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule